// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table in memory. The TLB hands it a 32-bit virtual address. The walker splits that address into a 10-bit directory index, a 10-bit table index and a 12-bit page offset. It first reads the directory word from the table whose base is held in a root register. If that word is valid, its frame number locates the second-level table, and the walker reads the leaf word from that table.

A valid leaf word goes back to the TLB for loading, together with the physical address that the leaf word produces. The TLB then retries the original translation. If either word has its valid bit clear, the walk stops at once and returns a fault code that names the level that failed.

Memory is reached through a read port that allows one request in flight at a time. A request is held until the memory accepts it, and the response comes back later as a single-cycle pulse. Only one walk runs at a time, and a new request is taken only when the walker is idle.

Top module: `ptw_walker`

## Requirements
- R1: While reset is active and on the first cycle after it, req_ready_o is 1 and mem_req_valid_o, done_o and fault_o are 0.
- R2: req_ready_o is 1 only while no walk is in progress. A request is taken only when req_valid_i and req_ready_o are both 1. The request inputs have no effect while a walk is running.
- R3: The first memory read goes to root + 4 × VA[31:22], where root is the byte address on root_base_i sampled when the request is taken.
- R4: The second read goes to {D[31:12], 12'h000} + 4 × VA[21:12], where D is the directory word returned by the first read.
- R5: Bit 0 of a table word is its valid bit, and no other bit affects validity. A directory word with bit 0 clear ends the walk with fault_o and fault_code_o = 2'b01, and no second read is issued.
- R6: A leaf word with bit 0 clear ends the walk with fault_o and fault_code_o = 2'b10, and done_o stays 0.
- R7: A valid leaf word produces done_o, with done_pte_o equal to the leaf word and rsp_pa_o = {leaf[31:12], VA[11:0]}.
- R8: done_o and fault_o are each high for exactly one cycle per walk and are never high together. fault_code_o is 2'b00 whenever fault_o is low.
- R9: mem_req_valid_o and mem_req_addr_o stay stable until mem_req_ready_i is seen. After a read is accepted, no further read is issued until its response has arrived.
- R10: A memory response that arrives while no read is outstanding is ignored: it causes no result and no state change.
- R11: Count the cycle in which the request is taken as cycle 0. When memory accepts each read at once and responds in the next cycle, done_o (or a second-level fault) is high in cycle 4 and a first-level fault in cycle 2. Each cycle of acceptance stall or response delay adds one cycle per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_base_i | input | 32 | Byte address of the directory table |
| req_valid_i | input | 1 | A walk request is offered |
| req_ready_o | output | 1 | The walker is idle and takes a request |
| req_va_i | input | 32 | Virtual address that missed |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 32 | Byte address of the table word to read |
| mem_rsp_valid_i | input | 1 | Read data is valid (one cycle) |
| mem_rsp_data_i | input | 32 | Table word that was read |
| done_o | output | 1 | One-cycle pulse: translation found |
| done_pte_o | output | 32 | Leaf word to load into the TLB, valid with done_o |
| rsp_pa_o | output | 32 | Physical address, valid with done_o |
| fault_o | output | 1 | One-cycle pulse: walk aborted |
| fault_code_o | output | 2 | 01 = directory invalid, 10 = leaf invalid |

## Verification
Every output is a registered state decode. A result therefore appears a fixed number of edges after the request is taken: four edges for a full walk and two for a first-level fault, plus one edge for every stall or delay cycle that the bench memory adds to each read. The scoreboard records the cycle in which the request was taken and stores the due cycle with each expected result. It samples on the falling edge and compares both the cycle and the payload. Each read address is popped from a queue at the moment memory accepts it, so an extra or missing read is reported at that read.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      S_IDLE     = 3'd0,
      S_FETCH_L1 = 3'd1,
      S_WAIT_L1  = 3'd2,
      S_FETCH_L2 = 3'd3,
      S_WAIT_L2  = 3'd4,
      S_DONE     = 3'd5,
      S_FAULT    = 3'd6
   } walk_state_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_DIR  = 2'b01,
      FLT_LEAF = 2'b10
   } walk_fault_e;

   localparam int unsigned PTE_VALID_BIT = 0;
   localparam int unsigned PTE_READ_BIT  = 1;
   localparam int unsigned PTE_WRITE_BIT = 2;
   localparam int unsigned PTE_EXEC_BIT  = 3;
   localparam int unsigned PTE_DIRTY_BIT = 4;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
   parameter int unsigned VA_W = 32,
   parameter int unsigned L1_W = 10,
   parameter int unsigned L2_W = 10,
   localparam int unsigned OFF_W = VA_W - L1_W - L2_W
) (
   input  logic [VA_W-1:0]  va_i,
   output logic [L1_W-1:0]  l1_idx_o,
   output logic [L2_W-1:0]  l2_idx_o,
   output logic [OFF_W-1:0] off_o
);

   localparam int unsigned L2_LO = OFF_W;
   localparam int unsigned L1_LO = OFF_W + L2_W;

   assign l1_idx_o = va_i[L1_LO +: L1_W];
   assign l2_idx_o = va_i[L2_LO +: L2_W];
   assign off_o    = va_i[OFF_W-1:0];

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int unsigned PA_W      = 32,
   parameter int unsigned L1_W      = 10,
   parameter int unsigned L2_W      = 10,
   parameter int unsigned OFF_W     = 12,
   parameter int unsigned PTE_W     = 32,
   parameter int unsigned ROOT_MODE = 0,
   localparam int unsigned FRAME_W   = PA_W - OFF_W,
   localparam int unsigned IDX_SHIFT = $clog2(PTE_W / 8)
) (
   input  logic               leaf_phase_i,
   input  logic [PA_W-1:0]    root_i,
   input  logic [L1_W-1:0]    l1_idx_i,
   input  logic [L2_W-1:0]    l2_idx_i,
   input  logic [FRAME_W-1:0] dir_frame_i,
   output logic [PA_W-1:0]    addr_o
);

   logic [PA_W-1:0] root_byte;
   logic [PA_W-1:0] dir_addr;
   logic [PA_W-1:0] leaf_addr;

   // ROOT_MODE 0: root_i is a byte address; 1: root_i carries a frame number
   if (ROOT_MODE == 0) begin : g_root_byte
      assign root_byte = root_i;
   end else begin : g_root_frame
      assign root_byte = {root_i[FRAME_W-1:0], {OFF_W{1'b0}}};
   end

   assign dir_addr  = root_byte + (PA_W'(l1_idx_i) << IDX_SHIFT);
   assign leaf_addr = {dir_frame_i, {OFF_W{1'b0}}} + (PA_W'(l2_idx_i) << IDX_SHIFT);
   assign addr_o    = leaf_phase_i ? leaf_addr : dir_addr;

endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
   import ptw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid_i,
   input  logic       mem_gnt_i,
   input  logic       mem_rsp_i,
   input  logic       pte_ok_i,
   output logic       req_ready_o,
   output logic       mem_req_o,
   output logic       leaf_phase_o,
   output logic       take_req_o,
   output logic       take_dir_o,
   output logic       take_leaf_o,
   output logic       done_o,
   output logic       fault_o,
   output logic [1:0] fault_code_o
);

   walk_state_e state_q, state_d;
   walk_fault_e flt_q, flt_d;

   always_comb begin
      state_d     = state_q;
      flt_d       = flt_q;
      take_req_o  = 1'b0;
      take_dir_o  = 1'b0;
      take_leaf_o = 1'b0;
      case (state_q)
         S_IDLE: begin
            if (req_valid_i) begin
               take_req_o = 1'b1;
               state_d    = S_FETCH_L1;
            end
         end
         S_FETCH_L1: begin
            if (mem_gnt_i) state_d = S_WAIT_L1;
         end
         S_WAIT_L1: begin
            if (mem_rsp_i) begin
               if (pte_ok_i) begin
                  take_dir_o = 1'b1;
                  state_d    = S_FETCH_L2;
               end else begin
                  flt_d   = FLT_DIR;
                  state_d = S_FAULT;
               end
            end
         end
         S_FETCH_L2: begin
            if (mem_gnt_i) state_d = S_WAIT_L2;
         end
         S_WAIT_L2: begin
            if (mem_rsp_i) begin
               if (pte_ok_i) begin
                  take_leaf_o = 1'b1;
                  state_d     = S_DONE;
               end else begin
                  flt_d   = FLT_LEAF;
                  state_d = S_FAULT;
               end
            end
         end
         S_DONE:  state_d = S_IDLE;
         S_FAULT: state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         flt_q   <= FLT_NONE;
      end else begin
         state_q <= state_d;
         flt_q   <= flt_d;
      end
   end

   assign req_ready_o  = (state_q == S_IDLE);
   assign mem_req_o    = (state_q == S_FETCH_L1) || (state_q == S_FETCH_L2);
   assign leaf_phase_o = (state_q == S_FETCH_L2);
   assign done_o       = (state_q == S_DONE);
   assign fault_o      = (state_q == S_FAULT);
   assign fault_code_o = (state_q == S_FAULT) ? flt_q : FLT_NONE;

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W      = 32,
   parameter int unsigned L1_W      = 10,
   parameter int unsigned L2_W      = 10,
   parameter int unsigned PTE_W     = 32,
   parameter int unsigned ROOT_MODE = 0,
   localparam int unsigned OFF_W    = VA_W - L1_W - L2_W,
   localparam int unsigned PA_W     = PTE_W,
   localparam int unsigned FRAME_W  = PA_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PA_W-1:0]  root_base_i,
   input  logic             req_valid_i,
   output logic             req_ready_o,
   input  logic [VA_W-1:0]  req_va_i,
   output logic             mem_req_valid_o,
   input  logic             mem_req_ready_i,
   output logic [PA_W-1:0]  mem_req_addr_o,
   input  logic             mem_rsp_valid_i,
   input  logic [PTE_W-1:0] mem_rsp_data_i,
   output logic             done_o,
   output logic [PTE_W-1:0] done_pte_o,
   output logic [PA_W-1:0]  rsp_pa_o,
   output logic             fault_o,
   output logic [1:0]       fault_code_o
);

   // elaboration-time parameter checks
   if (OFF_W < 1 || OFF_W >= PTE_W) begin : g_bad_split
      $fatal(1, "ptw_walker: index widths leave no valid page offset");
   end
   if (PTE_W != 32 && PTE_W != 64) begin : g_bad_pte
      $fatal(1, "ptw_walker: table word width must be 32 or 64");
   end
   if (((PTE_W / 8) << L1_W) > (1 << OFF_W) || ((PTE_W / 8) << L2_W) > (1 << OFF_W)) begin : g_bad_table
      $fatal(1, "ptw_walker: one table must fit in a single page");
   end
   if (ROOT_MODE > 1) begin : g_bad_mode
      $fatal(1, "ptw_walker: ROOT_MODE must be 0 or 1");
   end

   logic [VA_W-1:0]    va_q;
   logic [PA_W-1:0]    root_q;
   logic [FRAME_W-1:0] dir_frame_q;
   logic [PTE_W-1:0]   leaf_q;

   logic [L1_W-1:0]  l1_idx;
   logic [L2_W-1:0]  l2_idx;
   logic [OFF_W-1:0] va_off;

   logic mem_gnt, leaf_phase, take_req, take_dir, take_leaf;

   assign mem_gnt = mem_req_valid_o && mem_req_ready_i;

   ptw_va_split #(
      .VA_W (VA_W),
      .L1_W (L1_W),
      .L2_W (L2_W)
   ) u_split (
      .va_i     (va_q),
      .l1_idx_o (l1_idx),
      .l2_idx_o (l2_idx),
      .off_o    (va_off)
   );

   ptw_addr_gen #(
      .PA_W      (PA_W),
      .L1_W      (L1_W),
      .L2_W      (L2_W),
      .OFF_W     (OFF_W),
      .PTE_W     (PTE_W),
      .ROOT_MODE (ROOT_MODE)
   ) u_addr (
      .leaf_phase_i (leaf_phase),
      .root_i       (root_q),
      .l1_idx_i     (l1_idx),
      .l2_idx_i     (l2_idx),
      .dir_frame_i  (dir_frame_q),
      .addr_o       (mem_req_addr_o)
   );

   ptw_walk_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid_i),
      .mem_gnt_i    (mem_gnt),
      .mem_rsp_i    (mem_rsp_valid_i),
      .pte_ok_i     (mem_rsp_data_i[PTE_VALID_BIT]),
      .req_ready_o  (req_ready_o),
      .mem_req_o    (mem_req_valid_o),
      .leaf_phase_o (leaf_phase),
      .take_req_o   (take_req),
      .take_dir_o   (take_dir),
      .take_leaf_o  (take_leaf),
      .done_o       (done_o),
      .fault_o      (fault_o),
      .fault_code_o (fault_code_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q        <= '0;
         root_q      <= '0;
         dir_frame_q <= '0;
         leaf_q      <= '0;
      end else begin
         if (take_req) begin
            va_q   <= req_va_i;
            root_q <= root_base_i;
         end
         if (take_dir)  dir_frame_q <= mem_rsp_data_i[PTE_W-1:OFF_W];
         if (take_leaf) leaf_q      <= mem_rsp_data_i;
      end
   end

   assign done_pte_o = leaf_q;
   assign rsp_pa_o   = {leaf_q[PTE_W-1:OFF_W], va_off};

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int unsigned PTE_W = 32,
   parameter int unsigned PA_W  = 32,
   parameter int unsigned OFF_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid_i,
   input logic             req_ready_o,
   input logic             mem_req_valid_o,
   input logic             mem_req_ready_i,
   input logic [PA_W-1:0]  mem_req_addr_o,
   input logic             done_o,
   input logic [PTE_W-1:0] done_pte_o,
   input logic [PA_W-1:0]  rsp_pa_o,
   input logic             fault_o,
   input logic [1:0]       fault_code_o
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready_o |-> !mem_req_valid_o && !done_o && !fault_o); // R2

   AST_TAKE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && req_ready_o |=> !req_ready_o); // R2

   AST_DONE_LEAF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> done_pte_o[0]); // R7

   AST_PA_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> rsp_pa_o[PA_W-1:OFF_W] == done_pte_o[PTE_W-1:OFF_W]); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8

   AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> !fault_o); // R8

   AST_NO_DOUBLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fault_o)); // R8

   AST_CODE_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o ? ($countones(fault_code_o) == 1) : (fault_code_o == 2'b00)); // R8

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R9

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o); // R9

endmodule

bind ptw_walker ptw_walker_chk #(
   .PTE_W (PTE_W),
   .PA_W  (PA_W),
   .OFF_W (OFF_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_valid_i     (req_valid_i),
   .req_ready_o     (req_ready_o),
   .mem_req_valid_o (mem_req_valid_o),
   .mem_req_ready_i (mem_req_ready_i),
   .mem_req_addr_o  (mem_req_addr_o),
   .done_o          (done_o),
   .done_pte_o      (done_pte_o),
   .rsp_pa_o        (rsp_pa_o),
   .fault_o         (fault_o),
   .fault_code_o    (fault_code_o)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic [31:0] root_base_i;
   logic        req_valid_i;
   logic        req_ready_o;
   logic [31:0] req_va_i;
   logic        mem_req_valid_o;
   logic        mem_req_ready_i;
   logic [31:0] mem_req_addr_o;
   logic        mem_rsp_valid_i;
   logic [31:0] mem_rsp_data_i;
   logic        done_o;
   logic [31:0] done_pte_o;
   logic [31:0] rsp_pa_o;
   logic        fault_o;
   logic [1:0]  fault_code_o;

   ptw_walker u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .root_base_i     (root_base_i),
      .req_valid_i     (req_valid_i),
      .req_ready_o     (req_ready_o),
      .req_va_i        (req_va_i),
      .mem_req_valid_o (mem_req_valid_o),
      .mem_req_ready_i (mem_req_ready_i),
      .mem_req_addr_o  (mem_req_addr_o),
      .mem_rsp_valid_i (mem_rsp_valid_i),
      .mem_rsp_data_i  (mem_rsp_data_i),
      .done_o          (done_o),
      .done_pte_o      (done_pte_o),
      .rsp_pa_o        (rsp_pa_o),
      .fault_o         (fault_o),
      .fault_code_o    (fault_code_o)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_tests = 0;
   int n_fail  = 0;

   typedef struct {
      bit          is_fault;
      logic [1:0]  code;
      logic [31:0] pte;
      logic [31:0] pa;
      int          due;
   } exp_t;

   logic [31:0] mem_words [logic [31:0]];
   logic [31:0] addr_q [$];
   exp_t        exp_q [$];

   int ready_stall = 0;
   int rsp_dly     = 0;
   bit stray_req   = 1'b0;

   function automatic logic [31:0] rd(input logic [31:0] a);
      if (mem_words.exists(a)) return mem_words[a];
      return 32'h0;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   bit          pend = 1'b0;
   int          pcnt = 0;
   int          scnt = 0;
   logic [31:0] paddr;

   always @(negedge clk) begin
      mem_rsp_valid_i = 1'b0;
      if (stray_req) begin
         mem_rsp_valid_i = 1'b1;
         mem_rsp_data_i  = 32'hFFFF_FFFF;
         stray_req       = 1'b0;
      end
      if (mem_req_ready_i) begin
         mem_req_ready_i = 1'b0;
         pend = 1'b1;
         pcnt = 0;
      end
      if (pend) begin
         if (pcnt == rsp_dly) begin
            mem_rsp_valid_i = 1'b1;
            mem_rsp_data_i  = rd(paddr);
            pend = 1'b0;
         end else begin
            pcnt++;
         end
      end else if (rst_n && mem_req_valid_o) begin
         if (scnt == ready_stall) begin
            scnt = 0;
            mem_req_ready_i = 1'b1;
            paddr = mem_req_addr_o;
            if (addr_q.size() == 0) begin
               n_tests++;
               n_fail++;
               $display("FAIL R5 R9 unexpected read: actual %h expected none", mem_req_addr_o);
            end else begin
               check("R3/R4", "read address", mem_req_addr_o, addr_q.pop_front());
            end
         end else begin
            scnt++;
         end
      end
   end

   // ---------------- monitor ----------------
   bit prev_pulse = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_o && fault_o) check("R8", "done with fault", 32'd1, 32'd0);
         if (prev_pulse && (done_o || fault_o)) check("R8", "pulse length", 32'd2, 32'd1);
         prev_pulse = done_o || fault_o;
         if (done_o || fault_o) begin
            if (exp_q.size() == 0) begin
               n_tests++;
               n_fail++;
               $display("FAIL R8 unexpected result: actual done=%0b fault=%0b expected none", done_o, fault_o);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check("R11", "result cycle", cyc, e.due);
               if (e.is_fault) begin
                  check(e.code == 2'b01 ? "R5" : "R6", "fault flag", {31'd0, fault_o}, 32'd1);
                  check(e.code == 2'b01 ? "R5" : "R6", "fault code", {30'd0, fault_code_o}, {30'd0, e.code});
               end else begin
                  check("R7", "done flag", {31'd0, done_o}, 32'd1);
                  check("R7", "leaf word", done_pte_o, e.pte);
                  check("R7", "physical address", rsp_pa_o, e.pa);
               end
            end
         end else begin
            if (fault_code_o !== 2'b00) check("R8", "idle fault code", {30'd0, fault_code_o}, 32'd0);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic run_walk(input logic [31:0] va, input int hold);
      logic [31:0] a1, d1, a2, lf;
      exp_t e;
      int lat;
      lat = ready_stall + rsp_dly;
      a1 = root_base_i + {20'd0, va[31:22], 2'b00};
      d1 = rd(a1);
      addr_q.push_back(a1);
      e.pte = 32'h0;
      e.pa  = 32'h0;
      e.is_fault = 1'b0;
      e.code = 2'b00;
      if (!d1[0]) begin
         e.is_fault = 1'b1;
         e.code = 2'b01;
         e.due  = 2 + lat;
      end else begin
         a2 = {d1[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
         lf = rd(a2);
         addr_q.push_back(a2);
         e.due = 4 + 2 * lat;
         if (!lf[0]) begin
            e.is_fault = 1'b1;
            e.code = 2'b10;
         end else begin
            e.pte = lf;
            e.pa  = {lf[31:12], va[11:0]};
         end
      end
      @(negedge clk);
      while (!req_ready_o) @(negedge clk);
      req_va_i    = va;
      req_valid_i = 1'b1;
      @(posedge clk);
      #1;
      e.due = e.due + cyc;
      exp_q.push_back(e);
      @(negedge clk);
      // R2: a request held with another address must not disturb the walk
      for (int k = 0; k < hold; k++) begin
         req_va_i = va ^ 32'hFFC0_0000;
         @(negedge clk);
      end
      req_valid_i = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      check("R5", "reads left unissued", addr_q.size(), 32'd0);
   endtask

   initial begin
      #(4 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n           = 1'b0;
      root_base_i     = 32'h0010_0000;
      req_valid_i     = 1'b0;
      req_va_i        = 32'h0;
      mem_req_ready_i = 1'b0;
      mem_rsp_valid_i = 1'b0;
      mem_rsp_data_i  = 32'h0;

      mem_words[32'h0010_000C] = 32'h0020_0001;
      mem_words[32'h0020_0014] = 32'hABCD_E01F;
      mem_words[32'h0020_0018] = 32'hFFFF_F01E;
      mem_words[32'h0010_0FFC] = 32'h1234_5003;
      mem_words[32'h1234_5FFC] = 32'h5555_5011;
      mem_words[32'h0010_0000] = 32'h0030_0001;
      mem_words[32'h0030_0000] = 32'h0000_0001;
      mem_words[32'h0010_0020] = 32'hFFFF_FFFE;
      mem_words[32'h0040_000C] = 32'h0020_0001;

      repeat (2) @(negedge clk);
      check("R1", "ready in reset", {31'd0, req_ready_o}, 32'd1);
      check("R1", "read in reset", {31'd0, mem_req_valid_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "ready after reset", {31'd0, req_ready_o}, 32'd1);
      check("R1", "outputs after reset",
            {29'd0, mem_req_valid_o, done_o, fault_o}, 32'd0);

      run_walk(32'h00C0_59A4, 0); // R7 full walk
      run_walk(32'h01C0_0123, 0); // R5 empty directory slot
      run_walk(32'h00C0_9000, 0); // R6 empty leaf slot
      run_walk(32'hFFFF_FFFF, 0); // R3 R4 last indices, junk low bits in directory
      run_walk(32'h0000_0ABC, 0); // R7 first indices, frame zero
      run_walk(32'h0200_0000, 0); // R5 only bit 0 decides validity
      run_walk(32'h00C0_6000, 0); // R6 only bit 0 decides validity

      ready_stall = 2;
      rsp_dly     = 3;
      run_walk(32'h00C0_59A4, 0); // R9 R11 slow memory
      run_walk(32'h01C0_0123, 0); // R11 slow memory, first-level fault
      ready_stall = 0;
      rsp_dly     = 1;
      run_walk(32'hFFFF_F000, 0); // R11 response delay only

      ready_stall = 0;
      rsp_dly     = 0;
      run_walk(32'h00C0_5001, 3); // R2 inputs change during walk

      // R10 stray response while idle
      stray_req = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R10", "stray response result", {30'd0, done_o, fault_o}, 32'd0);
         check("R10", "stray response ready", {31'd0, req_ready_o}, 32'd1);
      end
      run_walk(32'h00C0_5FFF, 0); // R10 walk after stray response

      root_base_i = 32'h0040_0000;
      run_walk(32'h00C0_5123, 0); // R3 new root

      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule